// File: doc/BRIEF.md
# SD Host Global Register Wrapper

This block is the shared register front end for a host controller that carries one or two SD slot engines. A 32-bit read/write bus addresses a 4 KiB window. The lowest 256 bytes hold the global registers: a slot information word, debounce, bus, write-protect polarity, card detect and an interrupt status word. Each slot engine owns the 256-byte sub-window that starts at `(i+1)*0x100`. Accesses that fall there are handed to that slot's port with a select strobe.

Four offsets in the global page are aliases, not local storage. A read or write at one of them is forwarded to a slot's capability register or maximum-current register through dedicated mirror ports. Each slot's interrupt line is captured into the status word as a level, and the block's single interrupt output is the OR of the captured bits. A read returns its data one cycle after the request. A sticky error flag records any access that is not a full aligned 32-bit word, and any access that lands outside every mapped region.

Top module: `sdhost_glue_regs`

## Requirements
- R1: After reset the information word reads 0x00010000 with one slot configured, or 0x00030000 with two slots (bit 16 marks slot 0, bit 17 marks slot 1). Debounce (0x04) reads 0x00000005. Bus (0x08), write-protect polarity (0xEC), card detect (0xF0) and interrupt status (0xFC) read 0, and the error flag is low.
- R2: A write to the information word at 0x00 stores bits 31:1. Bit 0 is a reset request that always reads back as 0.
- R3: The words at 0x04, 0x08, 0xEC and 0xF0 store all 32 written bits and read them back unchanged.
- R4: Offsets 0x10 and 0x18 alias slot 0's capability and maximum-current registers, and 0x20 and 0x28 alias the same pair for slot 1. A write pulses that register's write strobe for one cycle, with the bus data on the mirror data port. A read returns the mirror input.
- R5: Bit n of the interrupt status word at 0xFC equals slot n's interrupt input as sampled at the previous clock edge. Bus writes to 0xFC have no effect.
- R6: The interrupt output is high exactly when any bit of the interrupt status word is high.
- R7: A full-word access at `(i+1)*0x100 + k` raises only `slot_sel[i]` in the same cycle, with `slot_addr = k`, `slot_wr` equal to the request's write flag and `slot_wdata` equal to the bus data. A read returns `slot_rdata` of slot i.
- R8: Every read request, and only a read request, produces `rsp_valid` high in the following cycle, with its data on `rsp_rdata`.
- R9: A full-word access at or above `(SLOTS+1)*0x100` has no effect, reads 0 and sets the error flag.
- R10: An access whose byte enables are not 4'b1111, or whose address bits 1:0 are not zero, changes no register and raises no strobe. It reads 0 and sets the error flag. The flag stays high until reset.
- R11: Other full-word offsets below 0x100 read 0, ignore writes and leave the error flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address inside the 4 KiB window |
| req_be | input | 4 | Byte enables; only 4'b1111 is a valid access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| slot_sel | output | SLOTS | Per-slot sub-window select |
| slot_wr | output | 1 | Write flag toward the slot engines |
| slot_addr | output | 8 | Offset inside the selected sub-window |
| slot_wdata | output | 32 | Write data toward the slot engines |
| slot_rdata | input | 32*SLOTS | Read data from each slot engine |
| slot_irq | input | SLOTS | Level interrupt from each slot |
| irq_out | output | 1 | Merged interrupt |
| cap_wr | output | SLOTS | Capability-register write strobe per slot |
| cur_wr | output | SLOTS | Maximum-current-register write strobe per slot |
| mir_wdata | output | 32 | Data for mirror writes |
| cap_rdata | input | 32*SLOTS | Capability register value of each slot |
| cur_rdata | input | 32*SLOTS | Maximum-current register value of each slot |
| err_flag | output | 1 | Sticky access-error flag |

## Verification
The most damaging faults are a bad address decode, which sends a strobe to the wrong slot or mirror in the same cycle as the request, and a wrong stored value, which shows up at the first read-back one cycle after that read. A captured interrupt bit that is stuck or lost shows on `irq_out` in the cycle after the slot line changes, so the bench compares that output against its own model on every clock. A rejected access that still leaks through is caught when the bench reads back the register that access could have changed.

// File: rtl/sdg_pkg.sv
package sdg_pkg;
  localparam int DW = 32;
  localparam int AW = 12;

  localparam logic [7:0] OFS_INFO = 8'h00;
  localparam logic [7:0] OFS_DEB  = 8'h04;
  localparam logic [7:0] OFS_BUS  = 8'h08;
  localparam logic [7:0] OFS_CAP0 = 8'h10;
  localparam logic [7:0] OFS_CUR0 = 8'h18;
  localparam logic [7:0] OFS_CAP1 = 8'h20;
  localparam logic [7:0] OFS_CUR1 = 8'h28;
  localparam logic [7:0] OFS_WPOL = 8'hEC;
  localparam logic [7:0] OFS_CDET = 8'hF0;
  localparam logic [7:0] OFS_IST  = 8'hFC;

  localparam logic [DW-1:0] DEB_RESET = 32'h0000_0005;

  typedef enum logic [3:0] {
    K_INFO, K_DEB, K_BUS, K_WPOL, K_CDET, K_IST,
    K_CAP, K_CUR, K_SLOT, K_RSVD, K_BAD
  } kind_e;

  typedef struct packed {
    kind_e kind;
    logic  idx;
  } dec_t;

  // Reset value of the information word for a given slot count.
  function automatic logic [DW-1:0] info_reset(input int nslot);
    logic [DW-1:0] v;
    v = 32'h0001_0000;
    if (nslot > 1) v = v | 32'h0002_0000;
    return v;
  endfunction

  // Classify one bus access: which resource it reaches and for which slot.
  function automatic dec_t classify(input logic [AW-1:0] a, input logic [3:0] be,
                                    input int nslot);
    dec_t d;
    d.kind = K_RSVD;
    d.idx  = 1'b0;
    if (be != 4'hF || a[1:0] != 2'b00) begin
      d.kind = K_BAD;
    end else if (a[11:8] == 4'h0) begin
      case (a[7:0])
        OFS_INFO: d.kind = K_INFO;
        OFS_DEB:  d.kind = K_DEB;
        OFS_BUS:  d.kind = K_BUS;
        OFS_WPOL: d.kind = K_WPOL;
        OFS_CDET: d.kind = K_CDET;
        OFS_IST:  d.kind = K_IST;
        OFS_CAP0: d.kind = K_CAP;
        OFS_CUR0: d.kind = K_CUR;
        OFS_CAP1: if (nslot > 1) begin d.kind = K_CAP; d.idx = 1'b1; end
        OFS_CUR1: if (nslot > 1) begin d.kind = K_CUR; d.idx = 1'b1; end
        default:  d.kind = K_RSVD;
      endcase
    end else if (int'(a[11:8]) <= nslot) begin
      d.kind = K_SLOT;
      d.idx  = a[9];
    end else begin
      d.kind = K_BAD;
    end
    return d;
  endfunction
endpackage

// File: rtl/sdg_decode.sv
module sdg_decode
  import sdg_pkg::*;
#(
  parameter int SLOTS = 2
) (
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [3:0]    req_be,
  output dec_t          dec,
  output logic          acc_bad
);
  always_comb begin
    dec     = classify(req_addr, req_be, SLOTS);
    acc_bad = req_valid && (dec.kind == K_BAD);
  end
endmodule

// File: rtl/sdg_gregs.sv
module sdg_gregs
  import sdg_pkg::*;
#(
  parameter int SLOTS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_wr,
  input  kind_e         kind,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] info_q,
  output logic [DW-1:0] deb_q,
  output logic [DW-1:0] bus_q,
  output logic [DW-1:0] wpol_q,
  output logic [DW-1:0] cdet_q
);
  localparam logic [DW-1:0] INFO_RST = info_reset(SLOTS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      info_q <= INFO_RST;
      deb_q  <= DEB_RESET;
      bus_q  <= '0;
      wpol_q <= '0;
      cdet_q <= '0;
    end else if (go_wr) begin
      case (kind)
        K_INFO: info_q <= {wdata[DW-1:1], 1'b0};
        K_DEB:  deb_q  <= wdata;
        K_BUS:  bus_q  <= wdata;
        K_WPOL: wpol_q <= wdata;
        K_CDET: cdet_q <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sdg_irq_merge.sv
module sdg_irq_merge #(
  parameter int SLOTS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SLOTS-1:0] slot_irq,
  output logic [SLOTS-1:0] irq_stat,
  output logic             irq_out
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_stat[i] <= 1'b0;
      else        irq_stat[i] <= slot_irq[i];
    end
  end

  assign irq_out = |irq_stat;
endmodule

// File: rtl/sdhost_glue_regs.sv
module sdhost_glue_regs
  import sdg_pkg::*;
#(
  parameter int SLOTS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [11:0]         req_addr,
  input  logic [3:0]          req_be,
  input  logic [31:0]         req_wdata,
  output logic                rsp_valid,
  output logic [31:0]         rsp_rdata,
  output logic [SLOTS-1:0]    slot_sel,
  output logic                slot_wr,
  output logic [7:0]          slot_addr,
  output logic [31:0]         slot_wdata,
  input  logic [32*SLOTS-1:0] slot_rdata,
  input  logic [SLOTS-1:0]    slot_irq,
  output logic                irq_out,
  output logic [SLOTS-1:0]    cap_wr,
  output logic [SLOTS-1:0]    cur_wr,
  output logic [31:0]         mir_wdata,
  input  logic [32*SLOTS-1:0] cap_rdata,
  input  logic [32*SLOTS-1:0] cur_rdata,
  output logic                err_flag
);
  dec_t          dec;
  logic          acc_bad;
  logic          go_wr;
  logic          go_rd;
  logic [DW-1:0] info_q, deb_q, bus_q, wpol_q, cdet_q;
  logic [SLOTS-1:0] irq_stat;
  logic [DW-1:0] rd_mux;
  logic [DW-1:0] cap_arr [2];
  logic [DW-1:0] cur_arr [2];
  logic [DW-1:0] slt_arr [2];

  sdg_decode #(.SLOTS(SLOTS)) u_dec (
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_be    (req_be),
    .dec       (dec),
    .acc_bad   (acc_bad)
  );

  assign go_wr = req_valid && req_write;
  assign go_rd = req_valid && !req_write;

  sdg_gregs #(.SLOTS(SLOTS)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_wr  (go_wr),
    .kind   (dec.kind),
    .wdata  (req_wdata),
    .info_q (info_q),
    .deb_q  (deb_q),
    .bus_q  (bus_q),
    .wpol_q (wpol_q),
    .cdet_q (cdet_q)
  );

  sdg_irq_merge #(.SLOTS(SLOTS)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_irq (slot_irq),
    .irq_stat (irq_stat),
    .irq_out  (irq_out)
  );

  // Per-slot strobes and gathered read sources.
  for (genvar i = 0; i < 2; i++) begin : g_slot
    if (i < SLOTS) begin : g_on
      assign cap_arr[i]  = cap_rdata[i*32 +: 32];
      assign cur_arr[i]  = cur_rdata[i*32 +: 32];
      assign slt_arr[i]  = slot_rdata[i*32 +: 32];
      assign slot_sel[i] = req_valid && dec.kind == K_SLOT && dec.idx == 1'(i);
      assign cap_wr[i]   = go_wr && dec.kind == K_CAP && dec.idx == 1'(i);
      assign cur_wr[i]   = go_wr && dec.kind == K_CUR && dec.idx == 1'(i);
    end else begin : g_off
      assign cap_arr[i] = '0;
      assign cur_arr[i] = '0;
      assign slt_arr[i] = '0;
    end
  end

  assign slot_wr    = req_write;
  assign slot_addr  = req_addr[7:0];
  assign slot_wdata = req_wdata;
  assign mir_wdata  = req_wdata;

  always_comb begin
    case (dec.kind)
      K_INFO:  rd_mux = info_q;
      K_DEB:   rd_mux = deb_q;
      K_BUS:   rd_mux = bus_q;
      K_WPOL:  rd_mux = wpol_q;
      K_CDET:  rd_mux = cdet_q;
      K_IST:   rd_mux = DW'(irq_stat);
      K_CAP:   rd_mux = cap_arr[dec.idx];
      K_CUR:   rd_mux = cur_arr[dec.idx];
      K_SLOT:  rd_mux = slt_arr[dec.idx];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      err_flag  <= 1'b0;
    end else begin
      rsp_valid <= go_rd;
      rsp_rdata <= go_rd ? rd_mux : '0;
      if (acc_bad) err_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/sdg_chk.sv
module sdg_chk #(
  parameter int SLOTS = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic [11:0]      req_addr,
  input logic [3:0]       req_be,
  input logic             rsp_valid,
  input logic [31:0]      rsp_rdata,
  input logic [SLOTS-1:0] slot_sel,
  input logic [SLOTS-1:0] slot_irq,
  input logic [SLOTS-1:0] cap_wr,
  input logic [SLOTS-1:0] cur_wr,
  input logic             irq_out,
  input logic             err_flag,
  input logic             acc_bad
);
  AST_INFO_BIT0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write && req_addr == 12'h000 && req_be == 4'hF |=> rsp_rdata[0] == 1'b0); // R2

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write |=> rsp_valid); // R8

  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid); // R8

  AST_IRQ_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_out == $past(|slot_irq)); // R6

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_sel)); // R7

  AST_BAD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_be != 4'hF |-> slot_sel == '0 && cap_wr == '0 && cur_wr == '0); // R10

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag); // R10

  AST_BAD_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    acc_bad |=> err_flag); // R10

  AST_UNMAPPED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_be == 4'hF && req_addr[1:0] == 2'b00 && int'(req_addr[11:8]) > SLOTS
    |=> err_flag); // R9
endmodule

bind sdhost_glue_regs sdg_chk #(.SLOTS(SLOTS)) u_chk (.*);

// File: tb/sdhost_glue_regs_tb_top.sv
module sdhost_glue_regs_tb_top;
  localparam int S = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [3:0]  req_be = 4'hF;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic [S-1:0] slot_sel, cap_wr, cur_wr;
  logic slot_wr, irq_out, err_flag;
  logic [7:0] slot_addr;
  logic [31:0] slot_wdata, mir_wdata;
  logic [S-1:0] slot_irq = '0;
  logic [32*S-1:0] slot_rdata, cap_rdata, cur_rdata;
  logic [31:0] cap_m [2];
  logic [31:0] cur_m [2];

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  assign slot_rdata = {32'hB1B1_0002, 32'hA0A0_0001};
  assign cap_rdata  = {cap_m[1], cap_m[0]};
  assign cur_rdata  = {cur_m[1], cur_m[0]};

  sdhost_glue_regs #(.SLOTS(S)) dut_i (.*);

  // Bench stand-in for the slot engines' capability/current registers.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_m[0] <= 32'h0160_00A1; cap_m[1] <= 32'h0160_00A2;
      cur_m[0] <= 32'h0000_0040; cur_m[1] <= 32'h0000_0080;
    end else begin
      for (int i = 0; i < S; i++) begin
        if (cap_wr[i]) cap_m[i] <= mir_wdata;
        if (cur_wr[i]) cur_m[i] <= mir_wdata;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Cycle model: previous read request and previous interrupt levels.
  logic m_rd;
  logic [S-1:0] m_irq;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_rd <= 1'b0; m_irq <= '0; end
    else begin m_rd <= req_valid && !req_write; m_irq <= slot_irq; end
  end
  always @(negedge clk) begin
    if (rst_n) begin
      chk(irq_out == (m_irq != '0), "R6 irq_out per cycle", 32'(irq_out), 32'(m_irq != '0));
      chk(rsp_valid == m_rd, "R8 rsp_valid per cycle", 32'(rsp_valid), 32'(m_rd));
    end
  end

  logic [S-1:0] p_sel, p_cap, p_cur;
  logic [7:0]   p_saddr;
  logic         p_swr;
  logic [31:0]  p_sdat, p_mdat;

  task automatic probe();
    #1;
    p_sel = slot_sel; p_cap = cap_wr; p_cur = cur_wr;
    p_saddr = slot_addr; p_swr = slot_wr; p_sdat = slot_wdata; p_mdat = mir_wdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_be = be; req_wdata = d;
    probe();
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_be = 4'hF;
  endtask

  task automatic rd(input logic [11:0] a, input logic [3:0] be, input logic [31:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = be;
    probe();
    @(negedge clk);
    req_valid = 1'b0; req_be = 4'hF;
    chk(rsp_valid && rsp_rdata == exp, tag, rsp_rdata, exp);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(err_flag == 1'b0, "R1 err after reset", 32'(err_flag), 0);
    rd(12'h000, 4'hF, 32'h0003_0000, "R1 info reset");
    rd(12'h004, 4'hF, 32'h0000_0005, "R1 debounce reset");
    rd(12'h008, 4'hF, 32'h0, "R1 bus reset");
    rd(12'h0EC, 4'hF, 32'h0, "R1 wpol reset");
    rd(12'h0F0, 4'hF, 32'h0, "R1 cdet reset");
    rd(12'h0FC, 4'hF, 32'h0, "R1 irq status reset");

    // R11 reserved global offsets
    wr(12'h040, 4'hF, 32'hCAFE_F00D);
    rd(12'h040, 4'hF, 32'h0, "R11 reserved reads zero");
    chk(err_flag == 1'b0, "R11 no error on reserved", 32'(err_flag), 0);

    // R2 self-clearing bit 0
    wr(12'h000, 4'hF, 32'hDEAD_BEEF);
    rd(12'h000, 4'hF, 32'hDEAD_BEEE, "R2 info bit0 cleared");
    wr(12'h000, 4'hF, 32'h0000_0001);
    rd(12'h000, 4'hF, 32'h0, "R2 info only reset bit");

    // R3 plain storage
    wr(12'h004, 4'hF, 32'h1234_5678);
    wr(12'h008, 4'hF, 32'h8765_4321);
    wr(12'h0EC, 4'hF, 32'hFFFF_FFFF);
    wr(12'h0F0, 4'hF, 32'hA5A5_5A5A);
    rd(12'h004, 4'hF, 32'h1234_5678, "R3 debounce rw");
    rd(12'h008, 4'hF, 32'h8765_4321, "R3 bus rw");
    rd(12'h0EC, 4'hF, 32'hFFFF_FFFF, "R3 wpol rw");
    rd(12'h0F0, 4'hF, 32'hA5A5_5A5A, "R3 cdet rw");

    // R4 mirrors
    wr(12'h010, 4'hF, 32'h0BAD_CAFE);
    chk(p_cap == 2'b01 && p_cur == 2'b00 && p_mdat == 32'h0BAD_CAFE, "R4 cap0 strobe",
        {p_cap, p_cur, p_mdat[27:0]}, {2'b01, 2'b00, 28'hBAD_CAFE});
    rd(12'h010, 4'hF, 32'h0BAD_CAFE, "R4 cap0 read");
    wr(12'h028, 4'hF, 32'h0000_0123);
    chk(p_cur == 2'b10 && p_cap == 2'b00, "R4 cur1 strobe", 32'({p_cur, p_cap}), 32'b1000);
    rd(12'h028, 4'hF, 32'h0000_0123, "R4 cur1 read");
    rd(12'h018, 4'hF, 32'h0000_0040, "R4 cur0 untouched");
    rd(12'h020, 4'hF, 32'h0160_00A2, "R4 cap1 untouched");

    // R5 / R6 interrupt capture and merge
    @(negedge clk); slot_irq = 2'b10;
    @(negedge clk);
    chk(irq_out == 1'b1, "R6 irq from slot1", 32'(irq_out), 1);
    rd(12'h0FC, 4'hF, 32'h2, "R5 status slot1");
    wr(12'h0FC, 4'hF, 32'hFFFF_FFFF);
    rd(12'h0FC, 4'hF, 32'h2, "R5 status write ignored");
    @(negedge clk); slot_irq = 2'b11;
    @(negedge clk); slot_irq = 2'b01;
    @(negedge clk);
    chk(irq_out == 1'b1, "R6 slot0 still pending", 32'(irq_out), 1);
    rd(12'h0FC, 4'hF, 32'h1, "R5 status slot0");
    @(negedge clk); slot_irq = 2'b00;
    @(negedge clk);
    chk(irq_out == 1'b0, "R6 irq drops", 32'(irq_out), 0);

    // R7 slot sub-windows
    rd(12'h104, 4'hF, 32'hA0A0_0001, "R7 slot0 read data");
    chk(p_sel == 2'b01 && p_saddr == 8'h04 && !p_swr, "R7 slot0 select",
        32'({p_sel, p_swr, p_saddr}), 32'({2'b01, 1'b0, 8'h04}));
    wr(12'h2F0, 4'hF, 32'h5555_AAAA);
    chk(p_sel == 2'b10 && p_saddr == 8'hF0 && p_swr && p_sdat == 32'h5555_AAAA, "R7 slot1 write",
        32'({p_sel, p_swr, p_saddr}), 32'({2'b10, 1'b1, 8'hF0}));
    rd(12'h2FC, 4'hF, 32'hB1B1_0002, "R7 slot1 read data");
    chk(err_flag == 1'b0, "R7 no error in windows", 32'(err_flag), 0);

    // R9 unmapped window
    rd(12'h300, 4'hF, 32'h0, "R9 unmapped reads zero");
    chk(err_flag == 1'b1, "R9 error set", 32'(err_flag), 1);
    wr(12'h510, 4'hF, 32'hFFFF_FFFF);
    chk(p_sel == 2'b00 && p_cap == 2'b00 && p_cur == 2'b00, "R9 no strobe",
        32'({p_sel, p_cap, p_cur}), 0);
    rd(12'h010, 4'hF, 32'h0BAD_CAFE, "R9 cap0 untouched");

    // R10 narrow / misaligned accesses, sticky flag
    do_reset();
    chk(err_flag == 1'b0, "R10 err cleared by reset", 32'(err_flag), 0);
    wr(12'h004, 4'h3, 32'hFFFF_FFFF);
    chk(err_flag == 1'b1, "R10 narrow write flags", 32'(err_flag), 1);
    rd(12'h004, 4'hF, 32'h0000_0005, "R10 narrow write dropped");
    wr(12'h012, 4'hF, 32'h0);
    chk(p_cap == 2'b00 && p_cur == 2'b00, "R10 misaligned no strobe", 32'({p_cap, p_cur}), 0);
    rd(12'h006, 4'hF, 32'h0, "R10 misaligned reads zero");
    rd(12'h004, 4'h1, 32'h0, "R10 narrow read zero");
    repeat (3) @(negedge clk);
    chk(err_flag == 1'b1, "R10 flag sticky", 32'(err_flag), 1);

    summary();
  end
endmodule